// File: doc/BRIEF.md
# MII Receive Frame Delineator

This block sits directly behind the 4-bit media-independent receive pins. It runs in the receive clock domain, which is 25 MHz for 100 Mb/s links. While data valid is high it hunts for the preamble and the start-of-frame delimiter. It then pairs the nibbles that follow into bytes. The result is a byte stream with a one-cycle byte strobe and a start-of-frame marker on the first byte. When data valid falls, an end-of-frame pulse is raised. That pulse carries three status flags: a receive error was seen, an odd nibble was left over, or the frame was cancelled.

A downstream filter can cancel the frame in progress through the abort input, for example when the destination address does not match. From that cycle until data valid drops, no further bytes are delivered. Checking the frame check sequence, filtering addresses and crossing to another clock domain are handled elsewhere.

Top module: `mii_rx_framer`

## Requirements
- R1: While reset is low and on the first cycle after it, every output is 0.
- R2: A frame is accepted only after at least one preamble nibble 0x5 immediately followed by the delimiter nibble 0xD, all with data valid high. The first data nibble is the one sampled on the cycle after the delimiter.
- R3: Before the delimiter, a nibble other than 0x5 or 0xD returns the block to hunting. A 0xD with no preamble nibble before it is also ignored. Neither case produces any byte or end-of-frame.
- R4: Each byte is built from two consecutive data nibbles: the first forms bits 3:0 and the second forms bits 7:4. The byte appears on `rx_byte` with `byte_vld` high for exactly one cycle, one clock after the second nibble is sampled.
- R5: `frame_sof` is high together with `byte_vld` on the first byte of a frame and on no other byte.
- R6: `frame_eof` pulses for exactly one cycle, one clock after data valid is sampled low, for every accepted frame, including a frame with no bytes.
- R7: `eof_dribble` is high with `frame_eof` when a frame that was not aborted ended after an odd number of data nibbles.
- R8: `eof_error` is high with `frame_eof` when the receive error input was high on any data-valid cycle after the delimiter. The flag is cleared for the next frame.
- R9: `abort_i` high on a data-valid cycle of an accepted frame discards that cycle's nibble and every later one until data valid drops. No further byte is delivered, and `frame_eof` carries `eof_aborted`.
- R10: `byte_vld` is never high on two consecutive cycles, and `frame_sof` and `frame_eof` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| abort_i | input | 1 | Cancel the frame in progress |
| rx_byte | output | 8 | Assembled byte |
| byte_vld | output | 1 | One-cycle strobe per assembled byte |
| frame_sof | output | 1 | Marks the first byte of a frame |
| frame_eof | output | 1 | One-cycle pulse after data valid drops |
| eof_error | output | 1 | Receive error seen in this frame (with eof) |
| eof_dribble | output | 1 | Odd nibble left over (with eof) |
| eof_aborted | output | 1 | Frame was cancelled by abort (with eof) |

## Verification
Some properties are checked by the assertions on every cycle:
- the byte strobe never fires twice in a row;
- start and end markers never coincide;
- a byte or an end-of-frame follows only the right data-valid level;
- no byte follows an abort or the discard state;
- the status flags appear only on the end-of-frame pulse.

Other behaviour can only be shown by the bench's frames. This covers the nibble order inside each byte, the exact byte contents, rejection of malformed preambles, dribble and error reporting, and the count of bytes delivered before an abort. Those frames mix random preamble lengths, payloads, error positions and abort points with directed corner cases.

// File: rtl/mii_rx_pkg.sv
// Shared types and defaults for the MII receive frame delineator.
// Assumes a 4-bit nibble interface; the values stay parameters so other
// nibble widths can reuse the same structure.
package mii_rx_pkg;

    localparam int          NIB_W_DEF   = 4;
    localparam logic [3:0]  PRE_NIB_DEF = 4'h5;
    localparam logic [3:0]  SFD_NIB_DEF = 4'hD;

    // Delineation state: hunting, inside preamble, inside data, discarding
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2,
        ST_DROP = 2'd3
    } rx_state_e;

endpackage

// File: rtl/mii_rx_sync_fsm.sv
// Frame synchroniser: finds the preamble run and the delimiter, then marks
// which nibbles are frame data and when the frame ends or is cancelled.
// Assumes inputs are already synchronous to clk. All outputs are
// combinational decodes of the current state and inputs.
module mii_rx_sync_fsm
    import mii_rx_pkg::*;
#(
    parameter int               NIB_W   = NIB_W_DEF,
    parameter logic [NIB_W-1:0] PRE_NIB = NIB_W'(PRE_NIB_DEF),
    parameter logic [NIB_W-1:0] SFD_NIB = NIB_W'(SFD_NIB_DEF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             dv_i,
    input  logic             er_i,
    input  logic             abort_i,
    output logic             frame_go_o,
    output logic             nib_take_o,
    output logic             frame_end_o,
    output logic             abort_hit_o,
    output logic             err_hit_o,
    output logic             dropping_o
);

    rx_state_e state_q, state_nx;
    logic      in_frame;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_nx;
    end

    // Next-state decode for hunting, preamble, data and discard
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (dv_i && nib_i == PRE_NIB) state_nx = ST_PRE;
            end
            ST_PRE: begin
                if (!dv_i)                    state_nx = ST_HUNT;
                else if (nib_i == SFD_NIB)    state_nx = ST_DATA;
                else if (nib_i != PRE_NIB)    state_nx = ST_HUNT;
            end
            ST_DATA: begin
                if (!dv_i)                    state_nx = ST_HUNT;
                else if (abort_i)             state_nx = ST_DROP;
            end
            ST_DROP: begin
                if (!dv_i)                    state_nx = ST_HUNT;
            end
            default:                          state_nx = ST_HUNT;
        endcase
    end

    // Per-cycle event decode for the packer and the status tracker
    always_comb begin
        in_frame    = (state_q == ST_DATA) || (state_q == ST_DROP);
        frame_go_o  = (state_q == ST_PRE) && dv_i && (nib_i == SFD_NIB);
        nib_take_o  = (state_q == ST_DATA) && dv_i && !abort_i;
        abort_hit_o = (state_q == ST_DATA) && dv_i && abort_i;
        frame_end_o = in_frame && !dv_i;
        err_hit_o   = in_frame && dv_i && er_i;
        dropping_o  = (state_q == ST_DROP);
    end

endmodule

// File: rtl/mii_rx_nibble_packer.sv
// Nibble packer: pairs accepted data nibbles into bytes, low nibble first,
// and marks the first byte after each delimiter. Outputs are registered.
// Assumes frame_go and nib_take never coincide (guaranteed by the FSM).
module mii_rx_nibble_packer #(
    parameter int NIB_W  = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go_i,
    input  logic              nib_take_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              sof_o,
    output logic              odd_o
);

    logic [NIB_W-1:0]  low_q;
    logic              half_q;
    logic              first_q;
    logic [BYTE_W-1:0] byte_q;
    logic              vld_q;
    logic              sof_q;

    // Hold the low nibble and the half-byte phase across a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= '0;
            half_q  <= 1'b0;
            first_q <= 1'b0;
        end else if (frame_go_i) begin
            half_q  <= 1'b0;
            first_q <= 1'b1;
        end else if (nib_take_i) begin
            if (!half_q) begin
                low_q  <= nib_i;
                half_q <= 1'b1;
            end else begin
                half_q  <= 1'b0;
                first_q <= 1'b0;
            end
        end
    end

    // Present a completed byte for one cycle with its start marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
            sof_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            sof_q <= 1'b0;
            if (nib_take_i && half_q) begin
                byte_q <= {nib_i, low_q};
                vld_q  <= 1'b1;
                sof_q  <= first_q;
            end
        end
    end

    assign byte_o     = byte_q;
    assign byte_vld_o = vld_q;
    assign sof_o      = sof_q;
    assign odd_o      = half_q;

    AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);                                     // R10
    AST_SOF_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        sof_q |-> vld_q);                                      // R5

endmodule

// File: rtl/mii_rx_status.sv
// Frame status tracker: collects receive-error and abort events over one
// frame and reports them, with the odd-nibble indication, on a one-cycle
// end-of-frame pulse. Assumes the frame_go/frame_end decode from the FSM.
module mii_rx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_go_i,
    input  logic frame_end_i,
    input  logic err_hit_i,
    input  logic abort_hit_i,
    input  logic odd_i,
    output logic eof_o,
    output logic eof_err_o,
    output logic eof_drb_o,
    output logic eof_abt_o
);

    logic err_q, abt_q;
    logic eof_q, eof_err_q, eof_drb_q, eof_abt_q;

    // Accumulate the per-frame error and abort conditions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            abt_q <= 1'b0;
        end else if (frame_go_i) begin
            err_q <= 1'b0;
            abt_q <= 1'b0;
        end else begin
            if (err_hit_i)   err_q <= 1'b1;
            if (abort_hit_i) abt_q <= 1'b1;
        end
    end

    // Issue the end-of-frame pulse with its flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eof_q     <= 1'b0;
            eof_err_q <= 1'b0;
            eof_drb_q <= 1'b0;
            eof_abt_q <= 1'b0;
        end else begin
            eof_q     <= frame_end_i;
            eof_err_q <= frame_end_i && err_q;
            eof_drb_q <= frame_end_i && odd_i && !abt_q;
            eof_abt_q <= frame_end_i && abt_q;
        end
    end

    assign eof_o     = eof_q;
    assign eof_err_o = eof_err_q;
    assign eof_drb_o = eof_drb_q;
    assign eof_abt_o = eof_abt_q;

    AST_DRIBBLE_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        eof_drb_q |-> eof_q);                                  // R7
    AST_ERROR_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        eof_err_q |-> eof_q);                                  // R8
    AST_ABORT_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        eof_abt_q |-> (eof_q && !eof_drb_q));                  // R9

endmodule

// File: rtl/mii_rx_framer.sv
// MII receive frame delineator top: synchroniser, nibble packer and status
// tracker. Everything runs on the receive clock; inputs are assumed
// synchronous. Output latency is one clock from the sampled nibble.
module mii_rx_framer
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rxd,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       abort_i,
    output logic [7:0] rx_byte,
    output logic       byte_vld,
    output logic       frame_sof,
    output logic       frame_eof,
    output logic       eof_error,
    output logic       eof_dribble,
    output logic       eof_aborted
);

    localparam int NIB_W = NIB_W_DEF;

    logic frame_go, nib_take, frame_end, abort_hit, err_hit, dropping, odd;

    mii_rx_sync_fsm #(
        .NIB_W   (NIB_W),
        .PRE_NIB (PRE_NIB_DEF),
        .SFD_NIB (SFD_NIB_DEF)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .nib_i       (rxd),
        .dv_i        (rx_dv),
        .er_i        (rx_er),
        .abort_i     (abort_i),
        .frame_go_o  (frame_go),
        .nib_take_o  (nib_take),
        .frame_end_o (frame_end),
        .abort_hit_o (abort_hit),
        .err_hit_o   (err_hit),
        .dropping_o  (dropping)
    );

    mii_rx_nibble_packer #(
        .NIB_W (NIB_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_go_i (frame_go),
        .nib_take_i (nib_take),
        .nib_i      (rxd),
        .byte_o     (rx_byte),
        .byte_vld_o (byte_vld),
        .sof_o      (frame_sof),
        .odd_o      (odd)
    );

    mii_rx_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_go_i  (frame_go),
        .frame_end_i (frame_end),
        .err_hit_i   (err_hit),
        .abort_hit_i (abort_hit),
        .odd_i       (odd),
        .eof_o       (frame_eof),
        .eof_err_o   (eof_error),
        .eof_drb_o   (eof_dribble),
        .eof_abt_o   (eof_aborted)
    );

    AST_BYTE_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(rx_dv));                            // R4
    AST_EOF_AFTER_DV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_eof |-> !$past(rx_dv));                          // R6
    AST_NO_BYTE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_hit || dropping) |=> !byte_vld);                // R9
    AST_SOF_EOF_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_sof, frame_eof}));                     // R10

endmodule

// File: tb/mii_rx_framer_bench.sv
`timescale 1ns/1ps
module mii_rx_framer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rxd = '0;
    logic       rx_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic       abort_i = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_vld, frame_sof, frame_eof;
    logic       eof_error, eof_dribble, eof_aborted;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Monitor storage (sole writer is the monitor process)
    logic [7:0] mon_b [256];
    bit         mon_s [256];
    int         mon_n = 0;
    int         eof_n = 0;
    bit         last_err, last_drb, last_abt;

    logic [7:0] payload [64];

    always #4 clk = ~clk;

    mii_rx_framer u_mii_rx_framer (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .abort_i(abort_i), .rx_byte(rx_byte), .byte_vld(byte_vld),
        .frame_sof(frame_sof), .frame_eof(frame_eof), .eof_error(eof_error),
        .eof_dribble(eof_dribble), .eof_aborted(eof_aborted)
    );

    // Capture bytes and end-of-frame events away from the active edge
    always @(negedge clk) begin
        if (byte_vld) begin
            mon_b[mon_n % 256] = rx_byte;
            mon_s[mon_n % 256] = frame_sof;
            mon_n = mon_n + 1;
        end
        if (frame_eof) begin
            last_err = eof_error;
            last_drb = eof_dribble;
            last_abt = eof_aborted;
            eof_n = eof_n + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] n, input logic dv, input logic er,
                         input logic ab);
        @(negedge clk);
        rxd = n; rx_dv = dv; rx_er = er; abort_i = ab;
    endtask

    task automatic gap();
        for (int i = 0; i < 4; i++) drive(4'h0, 1'b0, 1'b0, 1'b0);
    endtask

    // Expected number of delivered bytes: all, or those before the abort
    function automatic int exp_bytes(input int n, input int ab_idx);
        return (ab_idx >= 0 && ab_idx < n) ? ab_idx : n;
    endfunction

    // Send one well-formed frame and check everything the block reports
    task automatic send_frame(input int pre, input int n, input bit drib,
                              input int er_idx, input int ab_idx);
        int b0 = mon_n;
        int e0 = eof_n;
        int nb = exp_bytes(n, ab_idx);
        for (int i = 0; i < pre; i++) drive(4'h5, 1'b1, 1'b0, 1'b0);
        drive(4'hD, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            drive(payload[i][3:0], 1'b1, (i == er_idx), (i == ab_idx));
            drive(payload[i][7:4], 1'b1, 1'b0, 1'b0);
        end
        if (drib) drive(4'hA, 1'b1, 1'b0, 1'b0);
        gap();
        check("R9 byte count", mon_n - b0, nb);
        for (int i = 0; i < nb && i < mon_n - b0; i++) begin
            check("R4 byte value", int'(mon_b[(b0 + i) % 256]), int'(payload[i]));
            check("R5 sof marker", int'(mon_s[(b0 + i) % 256]), (i == 0) ? 1 : 0);
        end
        check("R6 eof count", eof_n - e0, 1);
        check("R8 error flag", int'(last_err), (er_idx >= 0) ? 1 : 0);
        check("R7 dribble flag", int'(last_drb), (drib && ab_idx < 0) ? 1 : 0);
        check("R9 aborted flag", int'(last_abt), (ab_idx >= 0) ? 1 : 0);
    endtask

    // Send a malformed start that must yield nothing
    task automatic send_reject(input bit with_pre);
        int b0 = mon_n;
        int e0 = eof_n;
        if (with_pre) begin
            drive(4'h5, 1'b1, 1'b0, 1'b0);
            drive(4'h5, 1'b1, 1'b0, 1'b0);
            drive(4'h3, 1'b1, 1'b0, 1'b0);
        end
        drive(4'hD, 1'b1, 1'b0, 1'b0);
        for (int i = 1; i < 4; i++) begin
            drive(4'(i), 1'b1, 1'b0, 1'b0);
            drive(4'(i), 1'b1, 1'b0, 1'b0);
        end
        gap();
        check("R3 no bytes", mon_n - b0, 0);
        check("R3 no eof", eof_n - e0, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        check("R1 reset byte_vld", int'(byte_vld), 0);
        check("R1 reset eof", int'(frame_eof | eof_error | eof_dribble | eof_aborted), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", int'(byte_vld | frame_sof | frame_eof), 0);

        // Directed: one-nibble preamble, short frame (R2)
        for (int i = 0; i < 64; i++) payload[i] = 8'(8'h10 + i * 7);
        send_frame(1, 4, 1'b0, -1, -1);
        // Full 15-nibble preamble, nine bytes then abort (R9)
        send_frame(15, 16, 1'b0, -1, 9);
        // Abort on the very first data nibble
        send_frame(7, 5, 1'b0, -1, 0);
        // Zero-byte frame: delimiter then drop (R6)
        send_frame(2, 0, 1'b0, -1, -1);
        // Dribble nibble (R7) and an error (R8)
        send_frame(3, 6, 1'b1, -1, -1);
        send_frame(3, 6, 1'b0, 2, -1);
        // Error flag must clear on the next frame
        send_frame(3, 3, 1'b0, -1, -1);
        // Malformed starts (R3)
        send_reject(1'b1);
        send_reject(1'b0);

        // Random frames
        for (int f = 0; f < 60; f++) begin
            int n, pre, er_idx, ab_idx;
            bit drib;
            n   = $urandom_range(30, 1);
            pre = $urandom_range(15, 1);
            for (int i = 0; i < n; i++) payload[i] = 8'($urandom);
            drib   = ($urandom % 4) == 0;
            er_idx = -1;
            ab_idx = -1;
            if (($urandom % 5) == 0)      er_idx = $urandom_range(n - 1, 0);
            else if (($urandom % 4) == 0) ab_idx = $urandom_range(n - 1, 0);
            send_frame(pre, n, drib, er_idx, ab_idx);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule